// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Controller

This block holds the state that guards writes to a serial flash memory. It takes single-cycle command strobes from a command decoder, along with the level of a write-protect pin. From these it keeps a write-enable latch, a protection-lock bit, a per-sector protection map and a tracker of the program or erase operation in progress. Each cycle it decides whether a modifying command is accepted. It also assembles the status byte that the bus interface returns to the host.

A modifying command is accepted only when the write-enable latch is set and no program or erase operation is running. Write-status and sector protect or unprotect commands take effect in the cycle they are accepted. Erase, byte-program and sequential-program commands start an operation, and that operation is ended later by done, abort or sequential-limit events from the array sequencer. The write-enable latch is consumed automatically by the completion or abort events that are defined for it.

Top module: `flash_status_ctrl`

## Requirements
- R1: When reset is sampled high, the next state has lock=0, write-enable=0, not busy, byte mode and every sector protected. `sector_map` then reads all ones, the summary reads 11 and `cmd_ok` reads 0.
- R2: A `cmd_wren` strobe sets the write-enable latch, and the latch is visible after the following clock edge. `cmd_wrdi` clears it. If a clear event and `cmd_wren` arrive in the same cycle, the latch ends at 0.
- R3: The pin is sampled through one register. While the sampled pin is low, an accepted write-status command loads the lock bit from `wrsr_lock`. While it is high, the lock bit can go from 0 to 1, but it cannot go from 1 to 0.
- R4: An accepted write-status command changes only the lock bit, and it clears the write-enable latch.
- R5: An accepted protect command sets bit `sec_sel` of the sector map, and an accepted unprotect command clears it. While the lock bit is 1, either command leaves the map unchanged but still clears the write-enable latch.
- R6: `status[3:2]` reads 00 when no sector is protected, 11 when all sectors are protected and 01 otherwise. It never reads 10.
- R7: The status byte is laid out as bit7 lock, bit6 sequential mode, bit5 constant 0, bit4 sampled pin, bits3:2 summary, bit1 write-enable and bit0 busy.
- R8: A write-status, protect, unprotect, erase, byte-program or sequential-program command is ignored while write-enable is 0 or busy is 1. `cmd_ok` pulses high for one cycle, after the edge, for each accepted one.
- R9: An accepted byte-program command sets busy. An `op_done` or `op_abort` strobe then clears busy and write-enable.
- R10: An accepted sequential-program command sets busy and the sequential-mode bit, and `op_done` leaves both unchanged. A `seq_limit` or `op_abort` strobe clears busy, the mode bit and write-enable.
- R11: An accepted erase command sets busy. `op_done` clears busy and keeps write-enable, while `op_abort` clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wp_pin | input | 1 | Write-protect pin, 1 = asserted |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Write-status strobe |
| wrsr_lock | input | 1 | Lock value carried by write-status |
| cmd_prot | input | 1 | Protect-sector strobe |
| cmd_unprot | input | 1 | Unprotect-sector strobe |
| sec_sel | input | 3 | Target sector index |
| cmd_erase | input | 1 | Erase start strobe |
| cmd_byte_pgm | input | 1 | Byte-program start strobe |
| cmd_seq_pgm | input | 1 | Sequential-program start strobe |
| op_done | input | 1 | Operation completion strobe |
| op_abort | input | 1 | Operation abort strobe |
| seq_limit | input | 1 | Sequential programming hit last writable location |
| status | output | 8 | Readable status byte |
| cmd_ok | output | 1 | Pulse for an accepted modifying command |
| sector_map | output | 8 | Per-sector protection bits |

## Verification
A latch that fails to clear shows up one cycle later as `status[1]` held high after a completion or abort. It also shows up as a `cmd_ok` pulse on a command that should have been refused. A corrupted lock bit or pin sample shows in `status[7]` and `status[4]` right after the edge. A corrupted sector bit shows in `sector_map` and in the summary field during the same cycle, so a model that compares every output on every clock finds any divergence within one cycle of its cause.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_ERASE = 2'd1,
    OP_BYTE  = 2'd2,
    OP_SEQ   = 2'd3
  } op_kind_t;

  localparam logic [1:0] SUM_NONE = 2'b00;
  localparam logic [1:0] SUM_SOME = 2'b01;
  localparam logic [1:0] SUM_ALL  = 2'b11;
endpackage

// File: rtl/fsc_wel.sv
module fsc_wel (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic wel_o
);
  always_ff @(posedge clk) begin
    if (rst)        wel_o <= 1'b0;
    else if (clr_i) wel_o <= 1'b0;
    else if (set_i) wel_o <= 1'b1;
  end

  // R2: a clear in the same cycle beats a set
  p_clear_wins_r2: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !wel_o);
  p_set_lands_r2: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i) |=> wel_o);
endmodule

// File: rtl/fsc_optrack.sv
module fsc_optrack
  import fsc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic go_erase_i,
  input  logic go_byte_i,
  input  logic go_seq_i,
  input  logic done_i,
  input  logic abort_i,
  input  logic limit_i,
  output logic busy_o,
  output logic seq_o,
  output logic wel_clr_o
);
  op_kind_t kind_q, kind_d;

  always_comb begin
    kind_d    = kind_q;
    wel_clr_o = 1'b0;
    unique case (kind_q)
      OP_IDLE: begin
        if (go_erase_i)     kind_d = OP_ERASE;
        else if (go_byte_i) kind_d = OP_BYTE;
        else if (go_seq_i)  kind_d = OP_SEQ;
      end
      OP_ERASE: begin
        if (abort_i) begin
          kind_d    = OP_IDLE;
          wel_clr_o = 1'b1;
        end else if (done_i) begin
          kind_d = OP_IDLE;
        end
      end
      OP_BYTE: begin
        if (abort_i || done_i) begin
          kind_d    = OP_IDLE;
          wel_clr_o = 1'b1;
        end
      end
      OP_SEQ: begin
        if (abort_i || limit_i) begin
          kind_d    = OP_IDLE;
          wel_clr_o = 1'b1;
        end
      end
      default: kind_d = OP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) kind_q <= OP_IDLE;
    else     kind_q <= kind_d;
  end

  assign busy_o = (kind_q != OP_IDLE);
  assign seq_o  = (kind_q == OP_SEQ);

  // R10: a completion strobe does not end a sequential session
  p_seq_done_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (seq_o && done_i && !abort_i && !limit_i) |=> (seq_o && busy_o));
  // R9: byte program end consumes the latch
  p_byte_end_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !seq_o && kind_q == OP_BYTE && done_i) |-> wel_clr_o);
  p_mode_implies_busy_r7: assert property (@(posedge clk) disable iff (rst)
    seq_o |-> busy_o);
endmodule

// File: rtl/fsc_sectors.sv
module fsc_sectors
  import fsc_pkg::*;
#(
  parameter int   SECTORS   = 8,
  parameter logic PROT_INIT = 1'b1,
  localparam int  SW        = $clog2(SECTORS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we_i,
  input  logic               val_i,
  input  logic [SW-1:0]      idx_i,
  output logic [SECTORS-1:0] map_o,
  output logic [1:0]         sum_o
);
  for (genvar g = 0; g < SECTORS; g++) begin : g_sec
    always_ff @(posedge clk) begin
      if (rst)                                    map_o[g] <= PROT_INIT;
      else if (we_i && idx_i == SW'(g))           map_o[g] <= val_i;
    end
  end

  always_comb begin
    if (&map_o)      sum_o = SUM_ALL;
    else if (|map_o) sum_o = SUM_SOME;
    else             sum_o = SUM_NONE;
  end

  // R6: unused code never appears
  p_sum_legal_r6: assert property (@(posedge clk) disable iff (rst)
    sum_o != 2'b10);
  // R5: sectors move only on a write
  p_map_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(map_o));
endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import fsc_pkg::*;
#(
  parameter int   SECTORS   = 8,
  parameter logic PROT_INIT = 1'b1,
  localparam int  SW        = $clog2(SECTORS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wp_pin,
  input  logic               cmd_wren,
  input  logic               cmd_wrdi,
  input  logic               cmd_wrsr,
  input  logic               wrsr_lock,
  input  logic               cmd_prot,
  input  logic               cmd_unprot,
  input  logic [SW-1:0]      sec_sel,
  input  logic               cmd_erase,
  input  logic               cmd_byte_pgm,
  input  logic               cmd_seq_pgm,
  input  logic               op_done,
  input  logic               op_abort,
  input  logic               seq_limit,
  output logic [7:0]         status,
  output logic               cmd_ok,
  output logic [SECTORS-1:0] sector_map
);
  logic wp_q, lock_q, wel, busy, seq_mode, op_clr;
  logic [1:0] sum;

  wire free       = wel && !busy;
  wire acc_wrsr   = cmd_wrsr && free;
  wire acc_prot   = cmd_prot && free;
  wire acc_unprot = cmd_unprot && free;
  wire acc_erase  = cmd_erase && free;
  wire acc_byte   = cmd_byte_pgm && free;
  wire acc_seq    = cmd_seq_pgm && free;
  wire sec_we     = (acc_prot || acc_unprot) && !lock_q;
  wire wel_clr    = cmd_wrdi || acc_wrsr || acc_prot || acc_unprot || op_clr;

  always_ff @(posedge clk) wp_q <= wp_pin;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      cmd_ok <= 1'b0;
    end else begin
      cmd_ok <= acc_wrsr || acc_prot || acc_unprot || acc_erase || acc_byte || acc_seq;
      if (acc_wrsr) lock_q <= wp_q ? (lock_q || wrsr_lock) : wrsr_lock;
    end
  end

  fsc_wel i_wel (
    .clk(clk), .rst(rst), .set_i(cmd_wren), .clr_i(wel_clr), .wel_o(wel)
  );

  fsc_optrack i_op (
    .clk(clk), .rst(rst),
    .go_erase_i(acc_erase), .go_byte_i(acc_byte), .go_seq_i(acc_seq),
    .done_i(op_done), .abort_i(op_abort), .limit_i(seq_limit),
    .busy_o(busy), .seq_o(seq_mode), .wel_clr_o(op_clr)
  );

  fsc_sectors #(.SECTORS(SECTORS), .PROT_INIT(PROT_INIT)) i_sec (
    .clk(clk), .rst(rst), .we_i(sec_we), .val_i(acc_prot), .idx_i(sec_sel),
    .map_o(sector_map), .sum_o(sum)
  );

  assign status = {lock_q, seq_mode, 1'b0, wp_q, sum, wel, busy};

  // R3: an asserted pin keeps a set lock set
  p_lock_held_r3: assert property (@(posedge clk) disable iff (rst)
    (lock_q && wp_q) |=> lock_q);
  // R5: a locked map stays put
  p_locked_map_r5: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> $stable(sector_map));
  // R8: nothing is accepted without the latch
  p_no_wel_no_ok_r8: assert property (@(posedge clk) disable iff (rst)
    !wel |=> !cmd_ok);
  // R2: write disable always empties the latch
  p_wrdi_clears_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_wrdi |=> !status[1]);
  // R4: the lock moves only on an accepted write-status
  p_lock_source_r4: assert property (@(posedge clk) disable iff (rst)
    !acc_wrsr |=> $stable(lock_q));
endmodule

// File: tb/test_flash_status_ctrl.sv
module test_flash_status_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wp_pin = 1'b0;
  logic [10:0] cv = '0;
  logic wrsr_lock = 1'b0;
  logic [2:0] sec_sel = '0;
  logic [7:0] status;
  logic cmd_ok;
  logic [7:0] sector_map;

  localparam int C_WREN = 0, C_WRDI = 1, C_WRSR = 2, C_PROT = 3, C_UNPROT = 4,
                 C_ERASE = 5, C_BYTE = 6, C_SEQ = 7, C_DONE = 8, C_ABORT = 9,
                 C_LIMIT = 10;

  always #2.5 clk = ~clk;

  flash_status_ctrl i_flash_status_ctrl (
    .clk(clk), .rst(rst), .wp_pin(wp_pin),
    .cmd_wren(cv[C_WREN]), .cmd_wrdi(cv[C_WRDI]), .cmd_wrsr(cv[C_WRSR]),
    .wrsr_lock(wrsr_lock), .cmd_prot(cv[C_PROT]), .cmd_unprot(cv[C_UNPROT]),
    .sec_sel(sec_sel), .cmd_erase(cv[C_ERASE]), .cmd_byte_pgm(cv[C_BYTE]),
    .cmd_seq_pgm(cv[C_SEQ]), .op_done(cv[C_DONE]), .op_abort(cv[C_ABORT]),
    .seq_limit(cv[C_LIMIT]), .status(status), .cmd_ok(cmd_ok),
    .sector_map(sector_map)
  );

  // behavioural reference: 0 idle, 1 erase, 2 byte, 3 sequential
  int   m_kind = 0;
  bit   m_lock = 0, m_wel = 0, m_ok = 0, m_wp = 0, m_valid = 0;
  bit [7:0] m_sec = 8'hFF;
  int   errors = 0, checks = 0, cycles = 0;
  string req = "R1";

  always @(posedge clk) begin
    bit clr, free;
    m_valid = 1;
    m_wp = wp_pin;
    if (rst) begin
      m_lock = 0; m_wel = 0; m_kind = 0; m_sec = 8'hFF; m_ok = 0;
    end else begin
      free = m_wel && (m_kind == 0);
      clr = cv[C_WRDI];
      m_ok = 0;
      if (free && cv[C_WRSR]) begin
        if (!m_wp || wrsr_lock) m_lock = wrsr_lock;
        m_ok = 1; clr = 1;
      end
      if (free && (cv[C_PROT] || cv[C_UNPROT])) begin
        if (!m_lock) m_sec[sec_sel] = cv[C_PROT];
        m_ok = 1; clr = 1;
      end
      if (m_kind == 1 && cv[C_ABORT]) begin m_kind = 0; clr = 1; end
      else if (m_kind == 1 && cv[C_DONE]) m_kind = 0;
      else if (m_kind == 2 && (cv[C_DONE] || cv[C_ABORT])) begin m_kind = 0; clr = 1; end
      else if (m_kind == 3 && (cv[C_LIMIT] || cv[C_ABORT])) begin m_kind = 0; clr = 1; end
      else if (free && cv[C_ERASE]) begin m_kind = 1; m_ok = 1; end
      else if (free && cv[C_BYTE])  begin m_kind = 2; m_ok = 1; end
      else if (free && cv[C_SEQ])   begin m_kind = 3; m_ok = 1; end
      if (clr) m_wel = 0;
      else if (cv[C_WREN]) m_wel = 1;
    end
  end

  always @(negedge clk) begin
    logic [7:0] exp_st;
    logic [1:0] sm;
    cycles++;
    if (m_valid && !rst) begin
      sm = (m_sec == 8'hFF) ? 2'b11 : (m_sec == 8'h00) ? 2'b00 : 2'b01;
      exp_st = {m_lock, m_kind == 3, 1'b0, m_wp, sm, m_wel, m_kind != 0};
      checks++;
      if (status !== exp_st || cmd_ok !== m_ok || sector_map !== m_sec) begin
        errors++;
        $display("FAIL %s: status=%h ok=%b map=%h expected status=%h ok=%b map=%h",
                 req, status, cmd_ok, sector_map, exp_st, m_ok, m_sec);
      end
    end
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected <=20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic issue(input int c, input logic [2:0] s = 3'd0, input logic d = 1'b0);
    @(negedge clk);
    cv = '0; cv[c] = 1'b1; sec_sel = s; wrsr_lock = d;
    @(negedge clk);
    cv = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst = 1'b0;
    req = "R1"; idle(2);                          // R1 reset state
    req = "R2"; issue(C_WREN); issue(C_WRDI);     // R2 set then clear
    issue(C_WREN);
    @(negedge clk) begin cv[C_WREN] = 1; cv[C_WRDI] = 1; end // R2 clear wins
    @(negedge clk) cv = '0;
    req = "R8"; issue(C_WRSR, 0, 1); issue(C_PROT, 2); issue(C_BYTE); // R8 rejected
    req = "R5";                                   // R5 and R6: walk the summary
    for (int i = 0; i < 8; i++) begin issue(C_WREN); issue(C_UNPROT, 3'(i)); end
    req = "R6";
    issue(C_WREN); issue(C_PROT, 5);
    for (int i = 0; i < 8; i++) begin issue(C_WREN); issue(C_PROT, 3'(i)); end
    req = "R4"; issue(C_WREN); issue(C_UNPROT, 1); issue(C_WREN); issue(C_WRSR, 0, 1); // R4
    req = "R5"; issue(C_WREN); issue(C_UNPROT, 4); issue(C_WREN); issue(C_PROT, 1);  // R5 locked
    req = "R3"; wp_pin = 1'b1; idle(2);           // R3 asymmetric lock
    issue(C_WREN); issue(C_WRSR, 0, 0);
    wp_pin = 1'b0; issue(C_WREN); issue(C_WRSR, 0, 0);
    wp_pin = 1'b1; issue(C_WREN); issue(C_WRSR, 0, 1);
    wp_pin = 1'b0; idle(1); issue(C_WREN); issue(C_WRSR, 0, 0);
    req = "R7"; wp_pin = 1'b1; idle(2); wp_pin = 1'b0; idle(2); // R7 pin mirror
    req = "R9"; issue(C_WREN); issue(C_BYTE); issue(C_WRSR, 0, 1); // R9 and R8 busy reject
    issue(C_DONE); issue(C_WREN); issue(C_BYTE); issue(C_ABORT);
    req = "R10"; issue(C_WREN); issue(C_SEQ); issue(C_DONE); issue(C_DONE); // R10
    issue(C_LIMIT); issue(C_WREN); issue(C_SEQ); issue(C_ABORT);
    req = "R11"; issue(C_WREN); issue(C_ERASE); issue(C_DONE);   // R11 keeps latch
    issue(C_ERASE); issue(C_ABORT); idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule